// File: doc/BRIEF.md
# Bridge Exclusive Access Lock Controller

This block tracks exclusive (locked) access through a two-port bus bridge. It decides when the bridge drives a lock onto the bus on the target side, how long it holds that lock, and when it lets go. While the lock is held, it stops the bridge from forwarding ordinary unlocked traffic. It does not handle arbitration, data movement or address decoding. Those blocks tell it when a request is forwarded and how it completed.

The initiator bus lock and frame strobes cross into the controller clock through a configurable sampling chain. The first locked request going downstream opens a lock attempt. A retry that ends this first request cancels the attempt. After that the lock stays up until the initiator is seen with both lock and frame inactive. If the target bus is still busy with a final posted write at that point, the lock is dropped when the write ends. Aborts on locked delayed requests are stored and returned when the initiator repeats the request. Aborts on locked posted writes cannot be returned, so they raise a one-cycle system-error strobe, gated by configuration bits. Every locked abort also sets a sticky status bit that software clears by writing one.

Top module: `xlock_ctrl`

## Requirements
- R1: A locked request that travels upstream (`req_upstream`=1) is forwarded as an ordinary transaction: `tgt_lock` stays 0 and `fwd_unlocked_ok` stays 1.
- R2: A downstream locked request (`req_valid`, `req_locked`=1, `req_upstream`=0) seen while idle raises `tgt_lock` one cycle later. `tgt_lock` then stays 1 across every later locked transaction until the initiator releases the lock.
- R3: A completion with code retry (`cpl_code`=2'b01) that ends the first transaction of a lock attempt drops `tgt_lock` one cycle later. A retry on any later transaction leaves `tgt_lock` at 1.
- R4: The release is taken only when `ini_lock`=0 and `ini_frame`=0 are sampled together. With the target bus idle, `tgt_lock` falls SAMPLE_STAGES+1 cycles after the inputs change. If `ini_lock` goes low while `ini_frame` stays high, the lock is held.
- R5: With RELEASE_WAIT=1, a release seen while `tgt_busy`=1 (for example during a final posted write) holds `tgt_lock` until the cycle after `tgt_busy` falls.
- R6: `fwd_unlocked_ok` is 0 in every cycle in which `tgt_lock` is 1, and returns to 1 in the same cycle that `tgt_lock` falls.
- R7: A target abort (`cpl_code`=2'b10) or master abort (2'b11) on a locked delayed request (`cpl_posted`=0) is stored. The next `req_repeat` while the lock is held gives a one-cycle `rsp_valid` with `rsp_code` equal to the stored code, one cycle after the repeat. That answer or the lock release clears the stored abort, so a later repeat gets no `rsp_valid`.
- R8: An abort on a locked posted write (`cpl_posted`=1) pulses `serr_pulse` for exactly one cycle, one cycle later, when `cfg_err_en`=1. A target abort needs nothing more. A master abort also needs `cfg_ma_mode`=1. With `cfg_err_en`=0 there is no pulse.
- R9: Each locked abort sets a sticky status bit one cycle later: `sts[0]` for a target abort and `sts[1]` for a master abort, whether the request was posted or delayed. A bit stays set until a cycle with the matching `sts_clr` bit at 1 clears it. A new event in the same cycle wins over the clear.
- R10: After reset, `tgt_lock`, `rsp_valid`, `serr_pulse` and `sts` are 0, and `fwd_unlocked_ok` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ini_lock | input | 1 | Initiator bus lock strobe, 1 = asserted |
| ini_frame | input | 1 | Initiator bus frame strobe, 1 = asserted |
| req_valid | input | 1 | A request is being forwarded this cycle |
| req_locked | input | 1 | The forwarded request asks for exclusive access |
| req_upstream | input | 1 | The forwarded request travels upstream |
| req_repeat | input | 1 | The initiator repeats a delayed request |
| cpl_valid | input | 1 | A target-side completion is reported this cycle |
| cpl_code | input | 2 | 00 normal, 01 retry, 10 target abort, 11 master abort |
| cpl_posted | input | 1 | The completing transaction was a posted write |
| tgt_busy | input | 1 | The target bus still has a transfer in progress |
| cfg_err_en | input | 1 | System-error reporting enable |
| cfg_ma_mode | input | 1 | Master aborts on posted writes also raise the system error |
| sts_clr | input | 2 | Write-one-to-clear strobes for `sts` |
| tgt_lock | output | 1 | Lock driven onto the target bus, 1 = asserted |
| fwd_unlocked_ok | output | 1 | Unlocked traffic may be forwarded |
| rsp_valid | output | 1 | A stored abort is returned to a repeated request |
| rsp_code | output | 2 | The abort code being returned |
| serr_pulse | output | 1 | One-cycle system-error strobe on the initiator bus |
| sts | output | 2 | Sticky status: bit 0 target abort, bit 1 master abort |

## Verification
The bench builds the block with SAMPLE_STAGES=2 and RELEASE_WAIT=1. The two sampling stages make the release latency three cycles, so the bench can check that the lock is still held one cycle before it falls. The waiting variant lets the bench keep `tgt_busy` high through a release and observe the lock held in the releasing state until the final posted write ends.

// File: rtl/xlock_pkg.sv
package xlock_pkg;
   localparam int XL_CODE_W = 2;
   localparam int XL_STS_W  = 2;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_PEND    = 2'd1,
      ST_LOCKED  = 2'd2,
      ST_RELEASE = 2'd3
   } xl_state_e;

   localparam logic [XL_CODE_W-1:0] CPL_OK     = 2'b00;
   localparam logic [XL_CODE_W-1:0] CPL_RETRY  = 2'b01;
   localparam logic [XL_CODE_W-1:0] CPL_TABORT = 2'b10;
   localparam logic [XL_CODE_W-1:0] CPL_MABORT = 2'b11;
endpackage

// File: rtl/xlock_sampler.sv
module xlock_sampler #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lock_i,
   input  logic frame_i,
   output logic lock_o,
   output logic frame_o
);
   generate
      if (STAGES == 0) begin : g_direct
         assign lock_o  = lock_i;
         assign frame_o = frame_i;
      end else begin : g_chain
         logic [STAGES-1:0] lk_q;
         logic [STAGES-1:0] fr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lk_q <= '0;
               fr_q <= '0;
            end else begin
               lk_q[0] <= lock_i;
               fr_q[0] <= frame_i;
               for (int i = 1; i < STAGES; i++) begin
                  lk_q[i] <= lk_q[i-1];
                  fr_q[i] <= fr_q[i-1];
               end
            end
         end
         assign lock_o  = lk_q[STAGES-1];
         assign frame_o = fr_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/xlock_fsm.sv
module xlock_fsm
   import xlock_pkg::*;
#(
   parameter int RELEASE_WAIT = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_locked,
   input  logic                 req_upstream,
   input  logic                 cpl_valid,
   input  logic [XL_CODE_W-1:0] cpl_code,
   input  logic                 rel_seen,
   input  logic                 tgt_busy,
   output xl_state_e            state
);
   xl_state_e nxt;
   logic      hold_busy;

   generate
      if (RELEASE_WAIT != 0) begin : g_wait
         assign hold_busy = tgt_busy;
      end else begin : g_nowait
         assign hold_busy = 1'b0;
      end
   endgenerate

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: begin
            if (req_valid && req_locked && !req_upstream)
               nxt = ST_PEND;
         end
         ST_PEND: begin
            if (cpl_valid && cpl_code == CPL_RETRY)
               nxt = ST_IDLE;
            else if (rel_seen)
               nxt = hold_busy ? ST_RELEASE : ST_IDLE;
            else if (cpl_valid)
               nxt = ST_LOCKED;
         end
         ST_LOCKED: begin
            if (rel_seen)
               nxt = hold_busy ? ST_RELEASE : ST_IDLE;
         end
         ST_RELEASE: begin
            if (!hold_busy)
               nxt = ST_IDLE;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/xlock_abort.sv
module xlock_abort
   import xlock_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 lock_act,
   input  logic                 cpl_valid,
   input  logic [XL_CODE_W-1:0] cpl_code,
   input  logic                 cpl_posted,
   input  logic                 req_repeat,
   input  logic                 cfg_err_en,
   input  logic                 cfg_ma_mode,
   input  logic [XL_STS_W-1:0]  sts_clr,
   output logic                 rsp_valid,
   output logic [XL_CODE_W-1:0] rsp_code,
   output logic                 serr_pulse,
   output logic [XL_STS_W-1:0]  sts
);
   logic                 stored_v;
   logic [XL_CODE_W-1:0] stored_code;
   logic                 is_abort, is_ta, is_ma, lk_abort;
   logic [XL_STS_W-1:0]  sts_set;

   assign is_ta    = cpl_valid && cpl_code == CPL_TABORT;
   assign is_ma    = cpl_valid && cpl_code == CPL_MABORT;
   assign is_abort = is_ta || is_ma;
   assign lk_abort = lock_act && is_abort;
   assign sts_set  = {lock_act && is_ma, lock_act && is_ta};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stored_v    <= 1'b0;
         stored_code <= CPL_OK;
         rsp_valid   <= 1'b0;
         rsp_code    <= CPL_OK;
         serr_pulse  <= 1'b0;
         sts         <= '0;
      end else begin
         rsp_valid  <= 1'b0;
         serr_pulse <= 1'b0;
         if (!lock_act) begin
            stored_v <= 1'b0;
         end else if (req_repeat && stored_v) begin
            rsp_valid <= 1'b1;
            rsp_code  <= stored_code;
            stored_v  <= 1'b0;
         end else if (lk_abort && !cpl_posted) begin
            stored_v    <= 1'b1;
            stored_code <= cpl_code;
         end
         if (lk_abort && cpl_posted && cfg_err_en && (is_ta || cfg_ma_mode))
            serr_pulse <= 1'b1;
         sts <= (sts & ~sts_clr) | sts_set;
      end
   end
endmodule

// File: rtl/xlock_ctrl.sv
module xlock_ctrl
   import xlock_pkg::*;
#(
   parameter int SAMPLE_STAGES = 2,
   parameter int RELEASE_WAIT  = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ini_lock,
   input  logic       ini_frame,
   input  logic       req_valid,
   input  logic       req_locked,
   input  logic       req_upstream,
   input  logic       req_repeat,
   input  logic       cpl_valid,
   input  logic [1:0] cpl_code,
   input  logic       cpl_posted,
   input  logic       tgt_busy,
   input  logic       cfg_err_en,
   input  logic       cfg_ma_mode,
   input  logic [1:0] sts_clr,
   output logic       tgt_lock,
   output logic       fwd_unlocked_ok,
   output logic       rsp_valid,
   output logic [1:0] rsp_code,
   output logic       serr_pulse,
   output logic [1:0] sts
);
   if (SAMPLE_STAGES < 0 || SAMPLE_STAGES > 4) begin : g_bad_stages
      $error("xlock_ctrl: SAMPLE_STAGES must lie in 0..4");
   end
   if (RELEASE_WAIT != 0 && RELEASE_WAIT != 1) begin : g_bad_wait
      $error("xlock_ctrl: RELEASE_WAIT must be 0 or 1");
   end

   logic      lock_s, frame_s, rel_seen;
   xl_state_e fsm_state;
   logic      lock_act;

   xlock_sampler #(.STAGES(SAMPLE_STAGES)) u_smp (
      .clk     (clk),
      .rst_n   (rst_n),
      .lock_i  (ini_lock),
      .frame_i (ini_frame),
      .lock_o  (lock_s),
      .frame_o (frame_s)
   );

   assign rel_seen = !lock_s && !frame_s;

   xlock_fsm #(.RELEASE_WAIT(RELEASE_WAIT)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_locked   (req_locked),
      .req_upstream (req_upstream),
      .cpl_valid    (cpl_valid),
      .cpl_code     (cpl_code),
      .rel_seen     (rel_seen),
      .tgt_busy     (tgt_busy),
      .state        (fsm_state)
   );

   assign lock_act        = fsm_state != ST_IDLE;
   assign tgt_lock        = lock_act;
   assign fwd_unlocked_ok = !lock_act;

   xlock_abort u_abt (
      .clk         (clk),
      .rst_n       (rst_n),
      .lock_act    (lock_act),
      .cpl_valid   (cpl_valid),
      .cpl_code    (cpl_code),
      .cpl_posted  (cpl_posted),
      .req_repeat  (req_repeat),
      .cfg_err_en  (cfg_err_en),
      .cfg_ma_mode (cfg_ma_mode),
      .sts_clr     (sts_clr),
      .rsp_valid   (rsp_valid),
      .rsp_code    (rsp_code),
      .serr_pulse  (serr_pulse),
      .sts         (sts)
   );
endmodule

// File: rtl/xlock_ctrl_chk.sv
module xlock_ctrl_chk
   import xlock_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input xl_state_e  fsm_state,
   input logic       rel_seen,
   input logic       req_valid,
   input logic       req_upstream,
   input logic       cpl_valid,
   input logic [1:0] cpl_code,
   input logic       tgt_busy,
   input logic       tgt_lock,
   input logic       fwd_unlocked_ok,
   input logic       rsp_valid,
   input logic [1:0] rsp_code,
   input logic       serr_pulse,
   input logic       cfg_err_en,
   input logic [1:0] sts,
   input logic [1:0] sts_clr
);
   AST_UPSTREAM_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (!tgt_lock && req_valid && req_upstream) |=> (!tgt_lock && fwd_unlocked_ok)); // R1
   AST_LOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_state == ST_LOCKED && !rel_seen) |=> tgt_lock); // R2
   AST_FIRST_RETRY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_state == ST_PEND && cpl_valid && cpl_code == CPL_RETRY) |=> (!tgt_lock && fwd_unlocked_ok)); // R3
   AST_LATER_RETRY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_state == ST_LOCKED && !rel_seen && cpl_valid && cpl_code == CPL_RETRY) |=> tgt_lock); // R3
   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_state == ST_RELEASE && tgt_busy) |=> tgt_lock); // R5
   AST_RSP_IS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_code[1]); // R7
   AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R7
   AST_SERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      serr_pulse |-> $past(cfg_err_en)); // R8
   AST_STS0_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sts[0] && !sts_clr[0]) |=> sts[0]); // R9
   AST_STS1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sts[1] && !sts_clr[1]) |=> sts[1]); // R9
endmodule

bind xlock_ctrl xlock_ctrl_chk u_chk (.*);

// File: tb/tb_xlock_ctrl.sv
module tb_xlock_ctrl;
   localparam int STG = 2;
   localparam int LAT = STG + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ini_lock = 0, ini_frame = 0, req_valid = 0, req_locked = 0, req_upstream = 0;
   logic req_repeat = 0, cpl_valid = 0, cpl_posted = 0, tgt_busy = 0;
   logic cfg_err_en = 0, cfg_ma_mode = 0;
   logic [1:0] cpl_code = 2'b00, sts_clr = 2'b00;
   logic tgt_lock, fwd_unlocked_ok, rsp_valid, serr_pulse;
   logic [1:0] rsp_code, sts;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   xlock_ctrl #(.SAMPLE_STAGES(STG), .RELEASE_WAIT(1)) dut (.*);

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic send_req(input logic lk, input logic up);
      @(negedge clk);
      req_valid = 1; req_locked = lk; req_upstream = up;
      @(negedge clk);
      req_valid = 0; req_locked = 0; req_upstream = 0;
   endtask

   task automatic send_cpl(input logic [1:0] code, input logic posted);
      @(negedge clk);
      cpl_valid = 1; cpl_code = code; cpl_posted = posted;
      @(negedge clk);
      cpl_valid = 0; cpl_code = 2'b00; cpl_posted = 0;
   endtask

   task automatic send_repeat();
      @(negedge clk);
      req_repeat = 1;
      @(negedge clk);
      req_repeat = 0;
   endtask

   task automatic lock_up();
      @(negedge clk);
      ini_lock = 1; ini_frame = 1;
      repeat (LAT) @(negedge clk);
      send_req(1'b1, 1'b0);
      send_cpl(2'b00, 1'b0);
   endtask

   task automatic release_idle();
      @(negedge clk);
      ini_lock = 0; ini_frame = 0;
      repeat (LAT) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R10 tgt_lock", tgt_lock, 0);
      chk("R10 fwd", fwd_unlocked_ok, 1);
      chk("R10 rsp_valid", rsp_valid, 0);
      chk("R10 serr", serr_pulse, 0);
      chk("R10 sts", sts, 0);
   endtask

   task automatic t_upstream();
      @(negedge clk);
      ini_lock = 1; ini_frame = 1;
      repeat (LAT) @(negedge clk);
      send_req(1'b1, 1'b1);
      chk("R1 upstream no lock", tgt_lock, 0);
      chk("R1 upstream fwd", fwd_unlocked_ok, 1);
      @(negedge clk);
      ini_lock = 0; ini_frame = 0;
      repeat (LAT) @(negedge clk);
   endtask

   task automatic t_first_retry();
      @(negedge clk);
      ini_lock = 1; ini_frame = 1;
      repeat (LAT) @(negedge clk);
      send_req(1'b1, 1'b0);
      chk("R2 lock raised", tgt_lock, 1);
      chk("R6 fwd blocked", fwd_unlocked_ok, 0);
      send_cpl(2'b01, 1'b0);
      chk("R3 first retry drops", tgt_lock, 0);
      chk("R6 fwd resumes", fwd_unlocked_ok, 1);
      release_idle();
   endtask

   task automatic t_hold_release();
      lock_up();
      chk("R2 lock after first", tgt_lock, 1);
      send_req(1'b1, 1'b0);
      send_cpl(2'b01, 1'b0);
      chk("R3 later retry keeps", tgt_lock, 1);
      send_cpl(2'b00, 1'b0);
      chk("R2 held later txn", tgt_lock, 1);
      @(negedge clk);
      ini_lock = 0;
      repeat (6) @(negedge clk);
      chk("R4 frame high holds", tgt_lock, 1);
      ini_frame = 0;
      repeat (LAT - 1) @(negedge clk);
      chk("R4 held before latency", tgt_lock, 1);
      @(negedge clk);
      chk("R4 dropped after latency", tgt_lock, 0);
      chk("R6 fwd after release", fwd_unlocked_ok, 1);
   endtask

   task automatic t_busy_release();
      lock_up();
      @(negedge clk);
      tgt_busy = 1;
      ini_lock = 0; ini_frame = 0;
      repeat (LAT + 4) @(negedge clk);
      chk("R5 held while busy", tgt_lock, 1);
      chk("R6 fwd blocked while busy", fwd_unlocked_ok, 0);
      tgt_busy = 0;
      @(negedge clk);
      chk("R5 drop after write end", tgt_lock, 0);
   endtask

   task automatic t_delayed_abort();
      lock_up();
      send_cpl(2'b10, 1'b0);
      chk("R9 sts ta set", sts, 1);
      chk("R8 no serr delayed", serr_pulse, 0);
      send_repeat();
      chk("R7 rsp valid", rsp_valid, 1);
      chk("R7 rsp code ta", rsp_code, 2);
      @(negedge clk);
      chk("R7 rsp one cycle", rsp_valid, 0);
      send_repeat();
      chk("R7 cleared after answer", rsp_valid, 0);
      send_cpl(2'b11, 1'b0);
      chk("R9 sts both", sts, 3);
      release_idle();
      chk("R2 released", tgt_lock, 0);
      lock_up();
      send_repeat();
      chk("R7 cleared by release", rsp_valid, 0);
      release_idle();
      @(negedge clk);
      sts_clr = 2'b01;
      @(negedge clk);
      sts_clr = 2'b00;
      chk("R9 w1c bit0", sts, 2);
      @(negedge clk);
      chk("R9 sticky", sts, 2);
      sts_clr = 2'b10;
      @(negedge clk);
      sts_clr = 2'b00;
      chk("R9 w1c bit1", sts, 0);
   endtask

   task automatic t_posted_abort();
      lock_up();
      cfg_err_en = 1; cfg_ma_mode = 0;
      send_cpl(2'b11, 1'b1);
      chk("R8 ma needs mode", serr_pulse, 0);
      chk("R9 ma sts posted", sts, 2);
      cfg_ma_mode = 1;
      send_cpl(2'b11, 1'b1);
      chk("R8 ma serr", serr_pulse, 1);
      @(negedge clk);
      chk("R8 serr one cycle", serr_pulse, 0);
      cfg_err_en = 0;
      send_cpl(2'b10, 1'b1);
      chk("R8 disabled", serr_pulse, 0);
      cfg_err_en = 1;
      send_cpl(2'b10, 1'b1);
      chk("R8 ta serr", serr_pulse, 1);
      send_repeat();
      chk("R7 posted not stored", rsp_valid, 0);
      @(negedge clk);
      sts_clr = 2'b11;
      cpl_valid = 1; cpl_code = 2'b10; cpl_posted = 1;
      @(negedge clk);
      sts_clr = 2'b00; cpl_valid = 0; cpl_code = 2'b00; cpl_posted = 0;
      chk("R9 set wins over clear", sts, 1);
      release_idle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_upstream();
      t_first_retry();
      t_hold_release();
      t_busy_release();
      t_delayed_abort();
      t_posted_abort();
      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule